// File: doc/BRIEF.md
# Paged Memory Window Translator

This block sits between a processor with a 16-bit data address space and a DRAM much larger than that space. The lower part of the processor space, 0x0000 to 0xEFFF, is cut into fifteen 4 KB windows. Each window has its own mapping register naming the DRAM block (4 KB unit) that the window currently shows. The block turns each processor access into a physical block number plus a 12-bit offset, and raises a DRAM select and a DRAM write strobe for it.

The mapping registers are loaded a byte at a time through ordinary processor writes to a small register area at the top of the address space. A memory-size input selects how block numbers fold onto the populated part of the DRAM, so that a small module aliases higher block numbers back onto its real storage. A global write gate, closed and opened by writes to two action addresses, suppresses DRAM write strobes while other devices share the write bus. All outputs are registered, one clock after the access is presented.

Top module: `pagewin_xlate`

## Requirements
- R1: After reset, dram_sel, dram_we and not_dram are 0, the write gate is open, and every window n (0 to 14) maps to block n.
- R2: A read or write (cpu_rd or cpu_wr high) at an address below 0xF000 raises dram_sel on the next clock, with dram_ofs equal to address bits [11:0].
- R3: For such an access, dram_block is the mapping register selected by address bits [15:12], after the size folding of R5.
- R4: A write to 0xFF00 + 2n + b, with n from 0 to 14, loads byte b of window n's 16-bit mapping register (b = 0 low byte, b = 1 high byte) and leaves every other byte unchanged; writes to 0xFF1E and 0xFF1F change no mapping.
- R5: mem_size folds the 13-bit block number: 0 (4 MB) keeps bits [9:0]; 1 (8 MB) keeps bits [10:0]; 2 (16 MB) keeps bits [11:0]; 3 (32 MB) keeps bits [12:0] with bit 10 forced to 0, so blocks land in 0–1023, 2048–3071, 4096–5119 or 6144–7167. Higher bits read 0.
- R6: A write of any data to 0xFFC0 closes the write gate and a write to 0xFFC1 opens it; the change applies to accesses presented on later clocks.
- R7: dram_we is high exactly when the access was a write below 0xF000 and the gate was open; it appears in the same cycle as dram_sel.
- R8: A read or write at 0xF000 or above gives not_dram = 1 with dram_sel = 0 and dram_we = 0; a cycle with no access gives all three at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Processor read strobe, one cycle per access |
| cpu_wr | input | 1 | Processor write strobe, one cycle per access |
| cpu_addr | input | 16 | Processor data address |
| cpu_wdata | input | 8 | Processor write data |
| mem_size | input | 2 | DRAM size code: 0 = 4 MB, 1 = 8 MB, 2 = 16 MB, 3 = 32 MB |
| dram_sel | output | 1 | Access falls in a DRAM window |
| dram_we | output | 1 | Gated DRAM write strobe |
| not_dram | output | 1 | Access falls at 0xF000 or above |
| dram_block | output | 13 | Physical DRAM block number after size folding |
| dram_ofs | output | 12 | Byte offset inside the block |

## Verification
Every output is one register stage after the access that caused it, so the bench presents an access on a falling edge, lets one rising edge pass, and reads the outputs on the next falling edge before the next access is driven. A mapping-register write or a gate write takes effect at the rising edge that samples it, so the first access presented after it already sees the new state, and the bench checks that access. The sweeps cover all fifteen windows under all four size codes with block numbers that carry bits above each size limit.

// File: rtl/pagewin_pkg.sv
package pagewin_pkg;
  typedef enum logic [1:0] {
    MSZ_4M  = 2'd0,
    MSZ_8M  = 2'd1,
    MSZ_16M = 2'd2,
    MSZ_32M = 2'd3
  } mem_size_e;
endpackage

// File: rtl/pagewin_regbank.sv
module pagewin_regbank #(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 4,
  parameter int MAP_W    = 16,
  parameter logic [ADDR_W-1:0] MAP_BASE = 16'hFF00
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [WIN_BITS-1:0] rd_win,
  output logic [MAP_W-1:0]    rd_map
);
  localparam int LANES       = MAP_W / 8;
  localparam int LANE_BITS   = $clog2(LANES);
  localparam int REGION_BITS = WIN_BITS + LANE_BITS;
  localparam int NSLOT       = 2 ** WIN_BITS;
  localparam int NWIN        = NSLOT - 1;

  logic                 hit;
  logic [WIN_BITS-1:0]  idx;
  logic [LANE_BITS-1:0] lane;
  logic [MAP_W-1:0]     map_q [NSLOT];

  assign hit  = wr_en && (wr_addr[ADDR_W-1:REGION_BITS] == MAP_BASE[ADDR_W-1:REGION_BITS]);
  assign idx  = wr_addr[LANE_BITS +: WIN_BITS];
  assign lane = wr_addr[LANE_BITS-1:0];

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam logic [MAP_W-1:0] IDENT = MAP_W'(w);
      logic [MAP_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= IDENT;
        end else if (hit && idx == WIN_BITS'(w)) begin
          for (int l = 0; l < LANES; l++) begin
            if (lane == LANE_BITS'(l)) q[8*l +: 8] <= wr_data;
          end
        end
      end
      assign map_q[w] = q;
    end
    // top slot has no register: it covers the non-DRAM region
    assign map_q[NWIN] = '0;
  endgenerate

  assign rd_map = map_q[rd_win];
endmodule

// File: rtl/pagewin_fold.sv
module pagewin_fold
  import pagewin_pkg::*;
#(
  parameter int MAP_W      = 16,
  parameter int GROUP_BITS = 10,
  parameter int BLK_W      = GROUP_BITS + 3
) (
  input  logic [MAP_W-1:0] raw,
  input  mem_size_e        size,
  output logic [BLK_W-1:0] blk
);
  int keep;

  always_comb begin
    case (size)
      MSZ_4M:  keep = GROUP_BITS;
      MSZ_8M:  keep = GROUP_BITS + 1;
      MSZ_16M: keep = GROUP_BITS + 2;
      default: keep = GROUP_BITS + 3;
    endcase
    for (int i = 0; i < BLK_W; i++) begin
      if (i >= keep) blk[i] = 1'b0;
      else if (size == MSZ_32M && i == GROUP_BITS) blk[i] = 1'b0;
      else blk[i] = raw[i];
    end
  end
endmodule

// File: rtl/pagewin_wrgate.sv
module pagewin_wrgate #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] OFF_ADDR = 16'hFFC0,
  parameter logic [ADDR_W-1:0] ON_ADDR  = 16'hFFC1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              gate_open
);
  always_ff @(posedge clk) begin
    if (rst) gate_open <= 1'b1;
    else if (wr_en && wr_addr == OFF_ADDR) gate_open <= 1'b0;
    else if (wr_en && wr_addr == ON_ADDR) gate_open <= 1'b1;
  end
endmodule

// File: rtl/pagewin_xlate.sv
module pagewin_xlate
  import pagewin_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFS_W      = 12,
  parameter int MAP_W      = 16,
  parameter int GROUP_BITS = 10,
  parameter logic [ADDR_W-1:0] MAP_BASE    = 16'hFF00,
  parameter logic [ADDR_W-1:0] WR_OFF_ADDR = 16'hFFC0,
  parameter logic [ADDR_W-1:0] WR_ON_ADDR  = 16'hFFC1,
  localparam int WIN_BITS = ADDR_W - OFS_W,
  localparam int BLK_W    = GROUP_BITS + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [1:0]        mem_size,
  output logic              dram_sel,
  output logic              dram_we,
  output logic              not_dram,
  output logic [BLK_W-1:0]  dram_block,
  output logic [OFS_W-1:0]  dram_ofs
);
  logic [WIN_BITS-1:0] win;
  logic                in_win;
  logic                access;
  logic                gate_open;
  logic [MAP_W-1:0]    raw_map;
  logic [BLK_W-1:0]    folded;

  assign win    = cpu_addr[ADDR_W-1:OFS_W];
  assign in_win = (win != '1);
  assign access = cpu_rd | cpu_wr;

  pagewin_regbank #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .MAP_W(MAP_W), .MAP_BASE(MAP_BASE)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(cpu_wr), .wr_addr(cpu_addr),
    .wr_data(cpu_wdata), .rd_win(win), .rd_map(raw_map)
  );

  pagewin_fold #(
    .MAP_W(MAP_W), .GROUP_BITS(GROUP_BITS), .BLK_W(BLK_W)
  ) u_fold (
    .raw(raw_map), .size(mem_size_e'(mem_size)), .blk(folded)
  );

  pagewin_wrgate #(
    .ADDR_W(ADDR_W), .OFF_ADDR(WR_OFF_ADDR), .ON_ADDR(WR_ON_ADDR)
  ) u_gate (
    .clk(clk), .rst(rst), .wr_en(cpu_wr), .wr_addr(cpu_addr), .gate_open(gate_open)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dram_sel   <= 1'b0;
      dram_we    <= 1'b0;
      not_dram   <= 1'b0;
      dram_block <= '0;
      dram_ofs   <= '0;
    end else begin
      dram_sel   <= access && in_win;
      dram_we    <= cpu_wr && in_win && gate_open;
      not_dram   <= access && !in_win;
      dram_block <= folded;
      dram_ofs   <= cpu_addr[OFS_W-1:0];
    end
  end
endmodule

// File: rtl/pagewin_chk.sv
module pagewin_chk #(
  parameter int ADDR_W     = 16,
  parameter int OFS_W      = 12,
  parameter int GROUP_BITS = 10,
  parameter int BLK_W      = GROUP_BITS + 3,
  parameter logic [ADDR_W-1:0] WR_OFF_ADDR = 16'hFFC0
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [1:0]        mem_size,
  input logic              dram_sel,
  input logic              dram_we,
  input logic              not_dram,
  input logic [BLK_W-1:0]  dram_block,
  input logic [OFS_W-1:0]  dram_ofs
);
  localparam int WIN_BITS = ADDR_W - OFS_W;

  // R2
  win_sel_chk: assert property (@(posedge clk) disable iff (rst)
    ((cpu_rd || cpu_wr) && cpu_addr[ADDR_W-1:OFS_W] != {WIN_BITS{1'b1}}) |=> dram_sel);

  // R2
  ofs_pass_chk: assert property (@(posedge clk) disable iff (rst)
    dram_sel |-> dram_ofs == $past(cpu_addr[OFS_W-1:0]));

  // R7
  we_in_sel_chk: assert property (@(posedge clk) disable iff (rst)
    dram_we |-> dram_sel);

  // R8
  high_excl_chk: assert property (@(posedge clk) disable iff (rst)
    not_dram |-> (!dram_sel && !dram_we));

  // R6
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cpu_wr && cpu_addr == WR_OFF_ADDR) && cpu_wr) |=> !dram_we);

  // R5
  fold_4m_chk: assert property (@(posedge clk) disable iff (rst)
    (dram_sel && $past(mem_size) == 2'd0) |-> dram_block[BLK_W-1:GROUP_BITS] == '0);

  // R5
  fold_32m_chk: assert property (@(posedge clk) disable iff (rst)
    (dram_sel && $past(mem_size) == 2'd3) |-> !dram_block[GROUP_BITS]);
endmodule

bind pagewin_xlate pagewin_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .GROUP_BITS(GROUP_BITS), .BLK_W(BLK_W),
  .WR_OFF_ADDR(WR_OFF_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .mem_size(mem_size), .dram_sel(dram_sel), .dram_we(dram_we), .not_dram(not_dram),
  .dram_block(dram_block), .dram_ofs(dram_ofs)
);

// File: tb/sim_pagewin_xlate.sv
`timescale 1ns/1ps
module sim_pagewin_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [1:0]  mem_size = 2'd3;
  logic        dram_sel, dram_we, not_dram;
  logic [12:0] dram_block;
  logic [11:0] dram_ofs;

  int checks = 0, errors = 0;
  bit done = 0;
  int model_map [15];

  always #10 clk = ~clk;

  pagewin_xlate u0 (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .mem_size(mem_size), .dram_sel(dram_sel), .dram_we(dram_we),
    .not_dram(not_dram), .dram_block(dram_block), .dram_ofs(dram_ofs)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int fold(input int b, input int sz);
    case (sz)
      0: return b % 1024;
      1: return b % 2048;
      2: return b % 4096;
      default: return (b % 8192) - (((b % 8192) / 1024) % 2) * 1024;
    endcase
  endfunction

  // present one access, return at the falling edge where its outputs are valid
  task automatic acc(input logic [15:0] a, input logic w, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wr = w; cpu_rd = !w; cpu_wdata = d;
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0;
  endtask

  task automatic set_map(input int w, input int v);
    acc(16'hFF00 + 16'(2 * w), 1'b1, 8'(v));
    acc(16'hFF00 + 16'(2 * w + 1), 1'b1, 8'(v >> 8));
    model_map[w] = v & 16'hFFFF;
  endtask

  task automatic win_access(input string req, input int w, input int ofs, input logic wr,
                            input logic gate);
    acc(16'((w << 12) | ofs), wr, 8'h3C);
    check({req, " sel"}, int'(dram_sel), 1);
    check({req, " ofs"}, int'(dram_ofs), ofs);
    check({req, " block"}, int'(dram_block), fold(model_map[w], int'(mem_size)));
    check({req, " we"}, int'(dram_we), int'(wr && gate));
    check({req, " notdram"}, int'(not_dram), 0);
  endtask

  initial begin
    for (int w = 0; w < 15; w++) model_map[w] = w;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 sel", int'(dram_sel), 0);
    check("R1 we", int'(dram_we), 0);
    check("R1 notdram", int'(not_dram), 0);

    // R1 identity map, R2 offset pass-through
    mem_size = 2'd3;
    for (int w = 0; w < 15; w++) win_access("R1 R2 identity", w, (w * 273 + 5) & 12'hFFF, w[0], 1'b1);

    // R4 program all windows byte by byte
    for (int w = 0; w < 15; w++) set_map(w, (w * 16'h02A7 + 16'h03C1 + (w << 13)) & 16'hFFFF);

    // R3 R5 R7 sweep all sizes and windows
    for (int s = 0; s < 4; s++) begin
      mem_size = 2'(s);
      for (int w = 0; w < 15; w++) win_access("R3 R5 R7 sweep", w, (w * 97 + s * 1000) & 12'hFFF, w[0] ^ s[0], 1'b1);
    end

    // R4 single byte lanes
    mem_size = 2'd3;
    acc(16'hFF06, 1'b1, 8'h5A);
    model_map[3] = (model_map[3] & 16'hFF00) | 16'h005A;
    win_access("R4 low lane", 3, 12'h123, 1'b0, 1'b1);
    acc(16'hFF07, 1'b1, 8'h1C);
    model_map[3] = (model_map[3] & 16'h00FF) | 16'h1C00;
    win_access("R4 high lane", 3, 12'h456, 1'b0, 1'b1);

    // R4 R8 slot 15 addresses change nothing
    acc(16'hFF1E, 1'b1, 8'hFF);
    check("R8 notdram slot15", int'(not_dram), 1);
    check("R8 sel slot15", int'(dram_sel), 0);
    acc(16'hFF1F, 1'b1, 8'hFF);
    for (int w = 0; w < 15; w++) win_access("R4 slot15 ignored", w, 12'hABC, 1'b0, 1'b1);

    // R5 wrap corner values
    set_map(0, 2048);
    mem_size = 2'd0; win_access("R5 4MB 2048->0", 0, 12'h010, 1'b0, 1'b1);
    set_map(1, 1029);
    mem_size = 2'd3; win_access("R5 32MB 1029->5", 1, 12'h020, 1'b0, 1'b1);
    set_map(2, 3072);
    win_access("R5 32MB 3072->2048", 2, 12'h030, 1'b0, 1'b1);
    set_map(4, 16'hFFFF);
    mem_size = 2'd1; win_access("R5 8MB all ones", 4, 12'hFFF, 1'b0, 1'b1);
    mem_size = 2'd2; win_access("R5 16MB all ones", 4, 12'h000, 1'b0, 1'b1);

    // R6 write gate
    mem_size = 2'd3;
    acc(16'hFFC0, 1'b1, 8'hA5);
    check("R6 gate write notdram", int'(not_dram), 1);
    check("R6 gate write we", int'(dram_we), 0);
    win_access("R6 closed write", 5, 12'h200, 1'b1, 1'b0);
    win_access("R6 closed read", 6, 12'h201, 1'b0, 1'b0);
    win_access("R6 still closed", 7, 12'h202, 1'b1, 1'b0);
    acc(16'hFFC1, 1'b1, 8'h00);
    win_access("R6 reopened", 5, 12'h203, 1'b1, 1'b1);

    // R8 high region and idle
    acc(16'hF000, 1'b0, 8'h00);
    check("R8 F000 rd notdram", int'(not_dram), 1);
    check("R8 F000 rd sel", int'(dram_sel), 0);
    acc(16'hF7FF, 1'b1, 8'h77);
    check("R8 F7FF wr notdram", int'(not_dram), 1);
    check("R8 F7FF wr we", int'(dram_we), 0);
    @(negedge clk);
    check("R8 idle sel", int'(dram_sel), 0);
    check("R8 idle we", int'(dram_we), 0);
    check("R8 idle notdram", int'(not_dram), 0);
    win_access("R8 F7FF write kept no map", 15 - 8, 12'h001, 1'b0, 1'b1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule